// File: doc/BRIEF.md
# Data-Space Address Generator and Decoder

This block forms the effective data-memory address for the load and store operations of a small 8-bit processor. It takes a mode code, a pointer select, a 16-bit direct address, a 6-bit unsigned displacement and the current values of three 16-bit pointer registers (called X, Y and Z here, with codes 0, 1 and 2). From these it produces the access address and, for the modes that change the pointer, a write-back of the new pointer value.

The effective address is decoded into exactly one of four regions of the data space: working registers, standard I/O, extended I/O and internal SRAM. The upper end of the SRAM region follows from the configured SRAM size. Register and I/O accesses finish in one cycle. SRAM accesses run for two cycles. While the first cycle of an SRAM access is in progress, any new start request is dropped. Instruction decode and the memories themselves sit outside this block.

Top module: `dsag_top`

## Requirements
- R1: Mode code 0 (direct) uses `direct_addr_i` as the address and asserts no pointer write-back.
- R2: Mode code 1 (indirect) uses the selected pointer as the address and asserts no pointer write-back.
- R3: Mode code 2 (displacement) uses the selected Y or Z pointer plus the unsigned 6-bit displacement (0 to 63) as the address, with no write-back.
- R4: Mode code 3 (pre-decrement) uses pointer minus one as the address. That same value is written back to the selected pointer: `ptr_we_o` is high for one cycle, with `ptr_wsel_o` set to the pointer code.
- R5: Mode code 4 (post-increment) uses the unchanged pointer as the address and writes back pointer plus one.
- R6: Pointer arithmetic wraps modulo 2^16: 0x0000 minus one gives 0xFFFF, and 0xFFFF plus one gives 0x0000.
- R7: Address 0x0000–0x001F asserts `sel_reg_o`. Address 0x0020–0x005F asserts `sel_io_o`. Address 0x0060–0x00FF asserts `sel_ext_o`. At most one select is high at any time.
- R8: Addresses from 0x0100 to 0x00FF + SRAM_KB*1024 (0x04FF at the default of 1) assert `sel_sram_o`. Any address above that asserts `oor_o` and no select.
- R9: For a register, I/O, out-of-range or illegal request, the outputs and a one-cycle `done_o` appear in the cycle after the start cycle.
- R10: An SRAM access holds `sel_sram_o` for two cycles after the start cycle. `done_o` is high only in the second of those cycles.
- R11: A start strobe during the first cycle of an SRAM access is ignored. The access finishes unchanged, and all outputs are idle afterwards.
- R12: Displacement mode with X, pointer select code 3 in any pointer mode, and mode codes 5–7 all raise `illegal_o` with `done_o`. In these cases no select and no write-back are asserted.
- R13: After reset, all selects, `oor_o`, `illegal_o`, `ptr_we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| direct_addr_i | input | 16 | Address for direct mode |
| disp_i | input | 6 | Unsigned displacement |
| ptr_x_i | input | 16 | Current X pointer |
| ptr_y_i | input | 16 | Current Y pointer |
| ptr_z_i | input | 16 | Current Z pointer |
| addr_o | output | 16 | Effective address of the last accepted request |
| sel_reg_o | output | 1 | Working-register region select |
| sel_io_o | output | 1 | Standard I/O region select |
| sel_ext_o | output | 1 | Extended I/O region select |
| sel_sram_o | output | 1 | SRAM region select |
| oor_o | output | 1 | Address above SRAM top |
| illegal_o | output | 1 | Illegal mode or pointer combination |
| ptr_we_o | output | 1 | Pointer write-back enable |
| ptr_wsel_o | output | 2 | Pointer being written back |
| ptr_wdata_o | output | 16 | New pointer value |
| done_o | output | 1 | Request complete |

## Verification
Some properties are checked by assertions on every cycle. The region selects stay mutually exclusive. An illegal or out-of-range request never carries a select. A register or I/O acceptance is always followed by `done_o`. The first SRAM cycle always leads into a second one in which done rises, even when a start arrives. Other behaviour can only be shown by the bench's directed scenarios: the actual address and write-back arithmetic of each mode, wrapping at the 16-bit edges, the exact region boundaries, and the SRAM top for the configured size.

// File: rtl/dsag_pkg.sv
package dsag_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DISP_W = 6;

  typedef enum logic [2:0] {
    MD_DIRECT  = 3'd0,
    MD_IND     = 3'd1,
    MD_DISP    = 3'd2,
    MD_PREDEC  = 3'd3,
    MD_POSTINC = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    PT_X = 2'd0,
    PT_Y = 2'd1,
    PT_Z = 2'd2
  } ptr_e;

  // region select bit positions in the 4-bit select vector
  localparam int unsigned RG_REG  = 0;
  localparam int unsigned RG_IO   = 1;
  localparam int unsigned RG_EXT  = 2;
  localparam int unsigned RG_SRAM = 3;
  localparam int unsigned NREG    = 4;
endpackage

// File: rtl/dsag_addr_calc.sv
module dsag_addr_calc
  import dsag_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [AW-1:0]     direct_addr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AW-1:0]     ptr_x_i,
  input  logic [AW-1:0]     ptr_y_i,
  input  logic [AW-1:0]     ptr_z_i,
  output logic [AW-1:0]     eff_addr_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_data_o,
  output logic              illegal_o
);
  logic [AW-1:0] base;
  logic          ptr_bad;

  always_comb begin
    ptr_bad = 1'b0;
    unique case (ptr_sel_i)
      PT_X:    base = ptr_x_i;
      PT_Y:    base = ptr_y_i;
      PT_Z:    base = ptr_z_i;
      default: begin base = '0; ptr_bad = 1'b1; end
    endcase
  end

  always_comb begin
    eff_addr_o = '0;
    wb_en_o    = 1'b0;
    wb_data_o  = '0;
    illegal_o  = 1'b0;
    case (mode_i)
      MD_DIRECT: eff_addr_o = direct_addr_i;
      MD_IND: begin
        eff_addr_o = base;
        illegal_o  = ptr_bad;
      end
      MD_DISP: begin
        eff_addr_o = base + AW'(disp_i);
        illegal_o  = ptr_bad || (ptr_sel_i == PT_X);
      end
      MD_PREDEC: begin
        eff_addr_o = base - AW'(1);
        wb_data_o  = base - AW'(1);
        wb_en_o    = !ptr_bad;
        illegal_o  = ptr_bad;
      end
      MD_POSTINC: begin
        eff_addr_o = base;
        wb_data_o  = base + AW'(1);
        wb_en_o    = !ptr_bad;
        illegal_o  = ptr_bad;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsag_region_dec.sv
module dsag_region_dec
  import dsag_pkg::*;
#(
  parameter int unsigned SRAM_KB = 1
) (
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] sel_o,
  output logic            oor_o
);
  localparam logic [AW-1:0] IO_BASE   = AW'(16'h0020);
  localparam logic [AW-1:0] EXT_BASE  = AW'(16'h0060);
  localparam logic [AW-1:0] SRAM_BASE = AW'(16'h0100);
  localparam logic [AW-1:0] SRAM_TOP  = AW'(32'h0100 + SRAM_KB * 1024 - 1);

  always_comb begin
    sel_o = '0;
    oor_o = 1'b0;
    if (addr_i < IO_BASE)        sel_o[RG_REG]  = 1'b1;
    else if (addr_i < EXT_BASE)  sel_o[RG_IO]   = 1'b1;
    else if (addr_i < SRAM_BASE) sel_o[RG_EXT]  = 1'b1;
    else if (addr_i <= SRAM_TOP) sel_o[RG_SRAM] = 1'b1;
    else                         oor_o          = 1'b1;
  end
endmodule

// File: rtl/dsag_seq.sv
module dsag_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sram_hit_i,
  output logic accept_o,
  output logic active_o,
  output logic done_o
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ONE   = 2'd1,
    ST_SRAM1 = 2'd2,
    ST_SRAM2 = 2'd3
  } st_e;

  st_e st_q, st_d;

  assign accept_o = start_i && (st_q != ST_SRAM1);
  assign active_o = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_ONE) || (st_q == ST_SRAM2);

  always_comb begin
    st_d = ST_IDLE;
    if (accept_o)               st_d = sram_hit_i ? ST_SRAM1 : ST_ONE;
    else if (st_q == ST_SRAM1)  st_d = ST_SRAM2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRAM1) |=> (st_q == ST_SRAM2)); // R11
  AST_SRAM_DONE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRAM1) |=> done_o); // R10
endmodule

// File: rtl/dsag_top.sv
module dsag_top
  import dsag_pkg::*;
#(
  parameter int unsigned SRAM_KB = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  mode_i,
  input  logic [1:0]  ptr_sel_i,
  input  logic [15:0] direct_addr_i,
  input  logic [5:0]  disp_i,
  input  logic [15:0] ptr_x_i,
  input  logic [15:0] ptr_y_i,
  input  logic [15:0] ptr_z_i,
  output logic [15:0] addr_o,
  output logic        sel_reg_o,
  output logic        sel_io_o,
  output logic        sel_ext_o,
  output logic        sel_sram_o,
  output logic        oor_o,
  output logic        illegal_o,
  output logic        ptr_we_o,
  output logic [1:0]  ptr_wsel_o,
  output logic [15:0] ptr_wdata_o,
  output logic        done_o
);
  logic [AW-1:0]   eff_addr, wb_data;
  logic            wb_en, ill;
  logic [NREG-1:0] dec_sel;
  logic            dec_oor;
  logic            accept, active, sram_hit;

  logic [AW-1:0]   addr_q, wdata_q;
  logic [NREG-1:0] sel_q, sel_d;
  logic            oor_q, oor_d, ill_q, we_q, we_d;
  logic [1:0]      wsel_q;

  dsag_addr_calc u_calc (
    .mode_i(mode_i), .ptr_sel_i(ptr_sel_i), .direct_addr_i(direct_addr_i),
    .disp_i(disp_i), .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i), .ptr_z_i(ptr_z_i),
    .eff_addr_o(eff_addr), .wb_en_o(wb_en), .wb_data_o(wb_data), .illegal_o(ill)
  );

  dsag_region_dec #(.SRAM_KB(SRAM_KB)) u_dec (
    .addr_i(eff_addr), .sel_o(dec_sel), .oor_o(dec_oor)
  );

  assign sram_hit = dec_sel[RG_SRAM] && !ill;

  dsag_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sram_hit_i(sram_hit),
    .accept_o(accept), .active_o(active), .done_o(done_o)
  );

  always_comb begin
    sel_d = ill ? '0 : dec_sel;
    oor_d = dec_oor && !ill;
    we_d  = accept && wb_en && !ill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= '0;
      oor_q   <= 1'b0;
      ill_q   <= 1'b0;
      wsel_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= eff_addr;
      sel_q   <= sel_d;
      oor_q   <= oor_d;
      ill_q   <= ill;
      wsel_q  <= ptr_sel_i;
      wdata_q <= wb_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  assign addr_o      = addr_q;
  assign sel_reg_o   = sel_q[RG_REG]  && active;
  assign sel_io_o    = sel_q[RG_IO]   && active;
  assign sel_ext_o   = sel_q[RG_EXT]  && active;
  assign sel_sram_o  = sel_q[RG_SRAM] && active;
  assign oor_o       = oor_q && active;
  assign illegal_o   = ill_q && active;
  assign ptr_we_o    = we_q;
  assign ptr_wsel_o  = wsel_q;
  assign ptr_wdata_o = wdata_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg_o, sel_io_o, sel_ext_o, sel_sram_o})); // R7
  AST_OOR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    oor_o |-> !(sel_reg_o || sel_io_o || sel_ext_o || sel_sram_o)); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !(sel_reg_o || sel_io_o || sel_ext_o || sel_sram_o || ptr_we_o)); // R12
  AST_SHORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sram_hit) |=> done_o); // R9
  AST_SRAM_FIRST_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sram_hit) |=> (sel_sram_o && !done_o)); // R10
endmodule

// File: tb/dsag_top_tb_top.sv
module dsag_top_tb_top;
  logic        clk, rst_n, start_i;
  logic [2:0]  mode_i;
  logic [1:0]  ptr_sel_i;
  logic [15:0] direct_addr_i, ptr_x_i, ptr_y_i, ptr_z_i;
  logic [5:0]  disp_i;
  logic [15:0] addr_o, ptr_wdata_o;
  logic        sel_reg_o, sel_io_o, sel_ext_o, sel_sram_o, oor_o, illegal_o;
  logic        ptr_we_o, done_o;
  logic [1:0]  ptr_wsel_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  dsag_top #(.SRAM_KB(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .direct_addr_i(direct_addr_i), .disp_i(disp_i),
    .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i), .ptr_z_i(ptr_z_i),
    .addr_o(addr_o), .sel_reg_o(sel_reg_o), .sel_io_o(sel_io_o),
    .sel_ext_o(sel_ext_o), .sel_sram_o(sel_sram_o), .oor_o(oor_o),
    .illegal_o(illegal_o), .ptr_we_o(ptr_we_o), .ptr_wsel_o(ptr_wsel_o),
    .ptr_wdata_o(ptr_wdata_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packed view: {sel_reg, sel_io, sel_ext, sel_sram, oor, illegal, we, done}
  function automatic logic [7:0] flags();
    return {sel_reg_o, sel_io_o, sel_ext_o, sel_sram_o, oor_o, illegal_o, ptr_we_o, done_o};
  endfunction

  // drive a request at a falling edge; return at the falling edge after the start cycle
  task automatic issue(input logic [2:0] md, input logic [1:0] ps,
                       input logic [15:0] da, input logic [5:0] dp);
    mode_i = md; ptr_sel_i = ps; direct_addr_i = da; disp_i = dp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 flags", {24'd0, flags()}, 32'h00);
  endtask

  task automatic t_direct();
    issue(3'd0, 2'd0, 16'h0045, 6'd0);
    chk("R1 addr", {16'd0, addr_o}, 32'h0045);
    chk("R7 io select, R9 done, R1 no wb", {24'd0, flags()}, 32'b0100_0001);
    idle_cycle();
    chk("R9 single-cycle done", {31'd0, done_o}, 0);
    issue(3'd0, 2'd0, 16'h005F, 6'd0);
    chk("R7 io upper edge", {24'd0, flags()}, 32'b0100_0001);
    issue(3'd0, 2'd0, 16'h0060, 6'd0);
    chk("R7 ext lower edge", {24'd0, flags()}, 32'b0010_0001);
    issue(3'd0, 2'd0, 16'h001F, 6'd0);
    chk("R7 reg upper edge", {24'd0, flags()}, 32'b1000_0001);
    idle_cycle();
  endtask

  task automatic t_indirect();
    issue(3'd1, 2'd0, 16'h0000, 6'd0);
    chk("R2 addr", {16'd0, addr_o}, 32'h0010);
    chk("R2 reg select no wb", {24'd0, flags()}, 32'b1000_0001);
    idle_cycle();
  endtask

  task automatic t_disp();
    issue(3'd2, 2'd2, 16'h0000, 6'h3F);
    chk("R3 Z+63 addr", {16'd0, addr_o}, 32'h008F);
    chk("R3 ext select no wb", {24'd0, flags()}, 32'b0010_0001);
    idle_cycle();
    issue(3'd2, 2'd1, 16'h0000, 6'd5);
    chk("R3 Y+5 addr", {16'd0, addr_o}, 32'h0205);
    chk("R10 first sram cycle", {24'd0, flags()}, 32'b0001_0000);
    idle_cycle();
    chk("R10 second sram cycle", {24'd0, flags()}, 32'b0001_0001);
    idle_cycle();
    chk("R10 idle after sram", {24'd0, flags()}, 32'h00);
  endtask

  task automatic t_predec();
    issue(3'd3, 2'd2, 16'h0000, 6'd0);
    chk("R4 addr", {16'd0, addr_o}, 32'h004F);
    chk("R4 wb flags", {24'd0, flags()}, 32'b0100_0011);
    chk("R4 wsel/wdata", {14'd0, ptr_wsel_o, ptr_wdata_o}, {14'd0, 2'd2, 16'h004F});
    idle_cycle();
    chk("R4 we single pulse", {31'd0, ptr_we_o}, 0);
  endtask

  task automatic t_postinc();
    issue(3'd4, 2'd1, 16'h0000, 6'd0);
    chk("R5 addr", {16'd0, addr_o}, 32'h0200);
    chk("R5 wsel/wdata", {14'd0, ptr_wsel_o, ptr_wdata_o}, {14'd0, 2'd1, 16'h0201});
    chk("R5 R10 sram first with wb", {24'd0, flags()}, 32'b0001_0010);
    idle_cycle();
    chk("R10 sram done", {24'd0, flags()}, 32'b0001_0001);
    idle_cycle();
  endtask

  task automatic t_wrap();
    ptr_x_i = 16'h0000; ptr_y_i = 16'hFFFF;
    issue(3'd3, 2'd0, 16'h0000, 6'd0);
    chk("R6 predec wrap addr", {16'd0, addr_o}, 32'hFFFF);
    chk("R6 predec wrap wdata", {16'd0, ptr_wdata_o}, 32'hFFFF);
    chk("R8 out of range flags", {24'd0, flags()}, 32'b0000_1011);
    issue(3'd4, 2'd1, 16'h0000, 6'd0);
    chk("R6 postinc wrap wdata", {16'd0, ptr_wdata_o}, 32'h0000);
    idle_cycle();
    ptr_x_i = 16'h0010; ptr_y_i = 16'h0200;
  endtask

  task automatic t_top();
    issue(3'd0, 2'd0, 16'h04FF, 6'd0);
    chk("R8 sram top", {24'd0, flags()}, 32'b0001_0000);
    idle_cycle();
    idle_cycle();
    issue(3'd0, 2'd0, 16'h0500, 6'd0);
    chk("R8 above top", {24'd0, flags()}, 32'b0000_1001);
    issue(3'd0, 2'd0, 16'h0100, 6'd0);
    chk("R8 sram base", {24'd0, flags()}, 32'b0001_0000);
    idle_cycle();
    idle_cycle();
  endtask

  task automatic t_ignore();
    issue(3'd0, 2'd0, 16'h0300, 6'd0);
    issue(3'd0, 2'd0, 16'h0001, 6'd0);
    chk("R11 addr kept", {16'd0, addr_o}, 32'h0300);
    chk("R11 sram completes", {24'd0, flags()}, 32'b0001_0001);
    idle_cycle();
    chk("R11 no late access", {24'd0, flags()}, 32'h00);
  endtask

  task automatic t_illegal();
    issue(3'd2, 2'd0, 16'h0000, 6'd1);
    chk("R12 disp with X", {24'd0, flags()}, 32'b0000_0101);
    issue(3'd6, 2'd1, 16'h0000, 6'd0);
    chk("R12 bad mode", {24'd0, flags()}, 32'b0000_0101);
    issue(3'd4, 2'd3, 16'h0000, 6'd0);
    chk("R12 bad pointer no wb", {24'd0, flags()}, 32'b0000_0101);
    idle_cycle();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; ptr_sel_i = '0;
    direct_addr_i = '0; disp_i = '0;
    ptr_x_i = 16'h0010; ptr_y_i = 16'h0200; ptr_z_i = 16'h0050;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_disp();
    t_predec();
    t_postinc();
    t_wrap();
    t_top();
    t_ignore();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule